// File: doc/BRIEF.md
# Charge Safety Timer Controller

This block guards the timed phases of a battery charger. A charge phase sequencer, outside the block, reports the current phase: idle, trickle, pre-charge, fast charge or top-off. A prescaler, also outside, supplies a one-cycle time tick. The block counts elapsed ticks in each phase against a selectable limit. When the limit is reached it raises a sticky safety-expired status and a charge-inhibit output, and pulses a one-cycle expiry event for the interrupt logic. A separate top-off timer, with three selectable lengths, reports when the top-off period is over.

The block holds its own six-bit timer configuration register. It is written through a strobe, read back on a port, and restored to defaults by a register-reset command. While input power limiting or thermal regulation is active, elapsed time can be made to advance at half rate. Limits are kept in minutes and multiplied by the parameter `TICKS_PER_MIN`. This lets a bench shrink hour-long limits to a few hundred cycles.

Top module: `chg_safety_timer`

## Requirements
- R1: After `rst`, `cfg_rdata` reads 6'h30, and `safety_expired`, `expire_evt`, `chg_inhibit` and `topoff_done` are low.
- R2: The configuration bits are `cfg_wdata[5]` slow-down enable, `[4]` safety timer enable, `[3]` short pre-charge limit, `[2]` long fast-charge limit and `[1:0]` top-off code. A write with `cfg_wr` appears on `cfg_rdata` the next cycle and governs the timers from then on.
- R3: `phase` encodes idle 0, trickle 1, pre-charge 2, fast 3 and top-off 4. In trickle and pre-charge, expiry follows 150 minutes of counted ticks when bit 3 is 0, and 37 minutes when bit 3 is 1.
- R4: In fast charge, expiry follows 870 minutes of counted ticks when bit 2 is 0, and 1680 minutes when bit 2 is 1.
- R5: When bit 5 is set and `in_reg_act` or `therm_reg_act` is high, only every second tick is counted, starting with the second. When bit 5 is clear, every tick counts.
- R6: With bit 4 clear, the safety timer does not count and never expires.
- R7: Once set, `safety_expired` and `chg_inhibit` stay high through phase changes and through `chg_en` going low. They clear only on `rst`, on `reg_reset`, or in the cycle after `chg_en` rises.
- R8: `expire_evt` is high for exactly the one cycle in which `safety_expired` first reads high.
- R9: The elapsed count restarts from zero on any change of `phase` and whenever `chg_en` is low.
- R10: In top-off with code 1, 2 or 3, `topoff_done` rises after 17, 35 or 52 minutes of ticks. These ticks are never slowed and do not depend on bit 4. `topoff_done` stays high until the phase leaves top-off. Code 0 never sets it.
- R11: `reg_reset` restores the configuration to 6'h30 and clears both timers and the expired status by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time tick from the prescaler |
| phase | input | 3 | Current charge phase code |
| chg_en | input | 1 | Charging enabled |
| in_reg_act | input | 1 | Input power limiting loop active |
| therm_reg_act | input | 1 | Thermal regulation loop active |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write data |
| reg_reset | input | 1 | Register-reset command |
| cfg_rdata | output | 6 | Current configuration |
| safety_expired | output | 1 | Sticky safety timer expired status |
| expire_evt | output | 1 | One-cycle expiry event |
| chg_inhibit | output | 1 | Charging inhibited by safety expiry |
| topoff_done | output | 1 | Top-off period complete |

## Verification
The bench hits exact expiry boundaries: the last tick before each limit and the tick that reaches it, at full and at half rate. A design with an off-by-one counter, or one that slows without skipping the first tick, shows the status a tick early or late. It changes phase and drops `chg_en` in the middle of a count, so a design that keeps stale elapsed time expires too soon. It also checks that expiry survives phase changes and a low `chg_en`, and that the event never lasts past one cycle. A cycle-accurate reference model, driven with seeded random ticks, regulation flags, configuration writes and register resets, catches disagreements anywhere else.

// File: rtl/chg_tmr_pkg.sv
package chg_tmr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_TRICKLE = 3'd1,
        PH_PRE     = 3'd2,
        PH_FAST    = 3'd3,
        PH_TOPOFF  = 3'd4
    } phase_e;

    typedef struct packed {
        logic       slow_en;
        logic       tmr_en;
        logic       pre_short;
        logic       fast_long;
        logic [1:0] topoff_sel;
    } tmr_cfg_t;

    localparam tmr_cfg_t CFG_RST = '{slow_en: 1'b1, tmr_en: 1'b1, pre_short: 1'b0,
                                     fast_long: 1'b0, topoff_sel: 2'd0};

    localparam int unsigned PRE_STD_MIN   = 150;
    localparam int unsigned PRE_SHORT_MIN = 37;
    localparam int unsigned FAST_STD_MIN  = 870;
    localparam int unsigned FAST_LONG_MIN = 1680;
    localparam int unsigned MAX_MIN       = FAST_LONG_MIN;

    function automatic logic is_timed(input phase_e ph);
        return (ph == PH_TRICKLE) || (ph == PH_PRE) || (ph == PH_FAST);
    endfunction

    function automatic int unsigned safety_minutes(input phase_e ph, input tmr_cfg_t c);
        case (ph)
            PH_TRICKLE, PH_PRE: return c.pre_short ? PRE_SHORT_MIN : PRE_STD_MIN;
            PH_FAST:            return c.fast_long ? FAST_LONG_MIN : FAST_STD_MIN;
            default:            return 0;
        endcase
    endfunction

    function automatic int unsigned topoff_minutes(input logic [1:0] sel);
        case (sel)
            2'd1:    return 17;
            2'd2:    return 35;
            2'd3:    return 52;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/chg_tmr_tick_gate.sv
module chg_tmr_tick_gate (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic slowed,
    output logic eff_tick
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            half_q <= 1'b0;
        else if (slowed && tick)
            half_q <= ~half_q;
        else if (!slowed)
            half_q <= 1'b0;
    end

    assign eff_tick = tick & (~slowed | half_q);

    // R5: two consecutive slowed ticks are never both counted
    a_r5_half_rate: assert property (@(posedge clk) disable iff (rst)
        (slowed && tick && !clr && eff_tick) |=> !(slowed && tick && eff_tick));

    // R5: a skipped slowed tick is followed by a counted one
    a_r5_alternate: assert property (@(posedge clk) disable iff (rst)
        (slowed && tick && !clr && !eff_tick) |=> (!(slowed && tick) || clr || eff_tick));

endmodule

// File: rtl/chg_tmr_safety_cnt.sv
module chg_tmr_safety_cnt #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             eff_tick,
    input  logic             rearm,
    input  logic [CNT_W-1:0] limit,
    output logic             expired,
    output logic             evt
);
    logic [CNT_W-1:0] cnt_q;
    logic             exp_q;
    logic             exp_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            exp_q   <= 1'b0;
            exp_d_q <= 1'b0;
        end else begin
            exp_d_q <= exp_q;
            if (clr) begin
                cnt_q <= '0;
            end else if (eff_tick && !exp_q) begin
                if (cnt_q >= limit - 1'b1) begin
                    cnt_q <= '0;
                    exp_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (rearm)
                exp_q <= 1'b0;
        end
    end

    assign expired = exp_q;
    assign evt     = exp_q & ~exp_d_q;

    // R7: expiry is sticky until charging is re-enabled
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (exp_q && !rearm) |=> exp_q);

    // R8: the expiry event never lasts two cycles
    a_r8_evt_single: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);

    // R9: a clear request empties the elapsed count
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/chg_tmr_topoff_cnt.sv
module chg_tmr_topoff_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (tick && !done_q) begin
            if (cnt_q >= limit - 1'b1)
                done_q <= 1'b1;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = done_q;

    // R10: done holds while top-off continues
    a_r10_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done_q && !clr) |=> done_q);

    // R10: the count is frozen once done
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        done_q |=> ($stable(cnt_q) || cnt_q == '0));

endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer
    import chg_tmr_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [2:0] phase,
    input  logic       chg_en,
    input  logic       in_reg_act,
    input  logic       therm_reg_act,
    input  logic       cfg_wr,
    input  logic [5:0] cfg_wdata,
    input  logic       reg_reset,
    output logic [5:0] cfg_rdata,
    output logic       safety_expired,
    output logic       expire_evt,
    output logic       chg_inhibit,
    output logic       topoff_done
);
    localparam int S_W = $clog2(MAX_MIN * TICKS_PER_MIN + 1);
    localparam int T_W = $clog2(52 * TICKS_PER_MIN + 1);

    tmr_cfg_t   cfg_q;
    logic [2:0] phase_q;
    logic       chg_q;
    phase_e     ph;
    logic       tmr_rst, s_clr, t_clr, slowed, rearm, eff_tick;
    logic [S_W-1:0] s_lim;
    logic [T_W-1:0] t_lim;

    always_ff @(posedge clk) begin
        if (rst || reg_reset)
            cfg_q <= CFG_RST;
        else if (cfg_wr)
            cfg_q <= tmr_cfg_t'(cfg_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 3'd0;
            chg_q   <= 1'b0;
        end else begin
            phase_q <= phase;
            chg_q   <= chg_en;
        end
    end

    always_comb begin
        ph      = phase_e'(phase);
        tmr_rst = rst | reg_reset;
        slowed  = cfg_q.slow_en & (in_reg_act | therm_reg_act);
        rearm   = chg_en & ~chg_q;
        s_clr   = (phase != phase_q) | ~chg_en | ~cfg_q.tmr_en | ~is_timed(ph);
        t_clr   = (ph != PH_TOPOFF) | (phase != phase_q) | ~chg_en | (cfg_q.topoff_sel == 2'd0);
        s_lim   = S_W'(safety_minutes(ph, cfg_q) * TICKS_PER_MIN);
        t_lim   = T_W'(topoff_minutes(cfg_q.topoff_sel) * TICKS_PER_MIN);
    end

    chg_tmr_tick_gate u_gate (
        .clk      (clk),
        .rst      (tmr_rst),
        .clr      (s_clr),
        .tick     (tick),
        .slowed   (slowed),
        .eff_tick (eff_tick)
    );

    chg_tmr_safety_cnt #(.CNT_W(S_W)) u_safety (
        .clk      (clk),
        .rst      (tmr_rst),
        .clr      (s_clr),
        .eff_tick (eff_tick),
        .rearm    (rearm),
        .limit    (s_lim),
        .expired  (safety_expired),
        .evt      (expire_evt)
    );

    chg_tmr_topoff_cnt #(.CNT_W(T_W)) u_topoff (
        .clk   (clk),
        .rst   (tmr_rst),
        .clr   (t_clr),
        .tick  (tick),
        .limit (t_lim),
        .done  (topoff_done)
    );

    assign cfg_rdata   = cfg_q;
    assign chg_inhibit = safety_expired;

    // R6: a disabled safety timer cannot raise expiry
    a_r6_disabled: assert property (@(posedge clk) disable iff (rst || reg_reset)
        (!cfg_q.tmr_en && !safety_expired) |=> !safety_expired);

    // R11: register reset restores the default configuration
    a_r11_cfg_restore: assert property (@(posedge clk) disable iff (rst)
        reg_reset |=> (cfg_rdata == 6'h30 && !safety_expired && !topoff_done));

    // R7: re-enabling charging clears the expired status
    a_r7_rearm: assert property (@(posedge clk) disable iff (rst || reg_reset)
        (chg_en && !chg_q) |=> !safety_expired);

endmodule

// File: tb/tb_chg_safety_timer.sv
module tb_chg_safety_timer;
    localparam int TPM = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] phase = 3'd0;
    logic       chg_en = 1'b0;
    logic       in_reg_act = 1'b0;
    logic       therm_reg_act = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [5:0] cfg_wdata = 6'd0;
    logic       reg_reset = 1'b0;
    logic [5:0] cfg_rdata;
    logic       safety_expired, expire_evt, chg_inhibit, topoff_done;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 1'b0;

    always #10 clk = ~clk;

    chg_safety_timer #(.TICKS_PER_MIN(TPM)) dut (
        .clk(clk), .rst(rst), .tick(tick), .phase(phase), .chg_en(chg_en),
        .in_reg_act(in_reg_act), .therm_reg_act(therm_reg_act),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .reg_reset(reg_reset),
        .cfg_rdata(cfg_rdata), .safety_expired(safety_expired),
        .expire_evt(expire_evt), .chg_inhibit(chg_inhibit), .topoff_done(topoff_done)
    );

    // Reference limits from the requirements
    function automatic int b_safety_lim(input logic [2:0] ph, input logic [5:0] c);
        if (ph == 3'd1 || ph == 3'd2) return (c[3] ? 37 : 150) * TPM;
        if (ph == 3'd3)               return (c[2] ? 1680 : 870) * TPM;
        return 0;
    endfunction

    function automatic int b_top_lim(input logic [1:0] code);
        case (code)
            2'd1: return 17 * TPM;
            2'd2: return 35 * TPM;
            2'd3: return 52 * TPM;
            default: return 0;
        endcase
    endfunction

    // Cycle model
    logic [5:0] m_cfg;
    logic [2:0] m_phq;
    logic       m_chgq, m_gate, m_exp, m_expd, m_done;
    int         m_cnt, m_tcnt;

    always @(posedge clk) begin
        logic slowed, sclr, tclr, eff;
        int   lim, tlim;
        if (rst) begin
            m_phq  <= 3'd0;
            m_chgq <= 1'b0;
        end else begin
            m_phq  <= phase;
            m_chgq <= chg_en;
        end
        if (rst || reg_reset) begin
            m_cfg <= 6'h30; m_cnt <= 0; m_gate <= 0; m_exp <= 0;
            m_expd <= 0; m_tcnt <= 0; m_done <= 0;
        end else begin
            if (cfg_wr) m_cfg <= cfg_wdata;
            m_expd <= m_exp;
            slowed = m_cfg[5] && (in_reg_act || therm_reg_act);
            sclr = (phase != m_phq) || !chg_en || !m_cfg[4] || !(phase >= 3'd1 && phase <= 3'd3);
            eff  = tick && (!slowed || m_gate);
            lim  = b_safety_lim(phase, m_cfg);
            if (sclr) m_gate <= 0;
            else if (slowed && tick) m_gate <= !m_gate;
            else if (!slowed) m_gate <= 0;
            if (sclr) m_cnt <= 0;
            else if (eff && !m_exp) begin
                if (m_cnt >= lim - 1) begin m_cnt <= 0; m_exp <= 1; end
                else m_cnt <= m_cnt + 1;
            end
            if (chg_en && !m_chgq) m_exp <= 0;
            tlim = b_top_lim(m_cfg[1:0]);
            tclr = (phase != 3'd4) || (phase != m_phq) || !chg_en || (m_cfg[1:0] == 2'd0);
            if (tclr) begin m_tcnt <= 0; m_done <= 0; end
            else if (tick && !m_done) begin
                if (m_tcnt >= tlim - 1) m_done <= 1;
                else m_tcnt <= m_tcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !rst) begin
            chk(cfg_rdata == m_cfg, "R2 model cfg", cfg_rdata, m_cfg);
            chk(safety_expired == m_exp, "R7 model expired", safety_expired, m_exp);
            chk(chg_inhibit == m_exp, "R7 model inhibit", chg_inhibit, m_exp);
            chk(expire_evt == (m_exp && !m_expd), "R8 model event", expire_evt, m_exp && !m_expd);
            chk(topoff_done == m_done, "R10 model topoff", topoff_done, m_done);
        end
    end

    task automatic idle1();
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic wr_cfg(input logic [5:0] v);
        cfg_wr = 1'b1; cfg_wdata = v; tick = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rearm();
        chg_en = 1'b0; idle1();
        chg_en = 1'b1; idle1();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        started = 1'b1;
        // R1 reset state
        chk(cfg_rdata == 6'h30, "R1 cfg default", cfg_rdata, 6'h30);
        chk(!safety_expired && !expire_evt && !chg_inhibit && !topoff_done, "R1 outputs low",
            {safety_expired, expire_evt, chg_inhibit, topoff_done}, 0);
        idle1();
        // R2 write and readback
        wr_cfg(6'h26);
        chk(cfg_rdata == 6'h26, "R2 readback", cfg_rdata, 6'h26);
        // R3 short pre-charge limit, R8 event
        wr_cfg(6'h38);
        chg_en = 1'b1; phase = 3'd2; idle1();
        ticks(36); chk(!safety_expired, "R3 before short limit", safety_expired, 0);
        ticks(1);
        chk(safety_expired, "R3 at short limit", safety_expired, 1);
        chk(expire_evt, "R8 event on rise", expire_evt, 1);
        chk(chg_inhibit, "R7 inhibit", chg_inhibit, 1);
        idle1();
        chk(!expire_evt, "R8 event one cycle", expire_evt, 0);
        // R7 sticky
        phase = 3'd3; idle1(); ticks(10);
        chk(safety_expired, "R7 across phase change", safety_expired, 1);
        chg_en = 1'b0; idle1();
        chk(safety_expired, "R7 while disabled", safety_expired, 1);
        chg_en = 1'b1; idle1();
        chk(!safety_expired, "R7 cleared on re-enable", safety_expired, 0);
        // R9 phase change clears count
        phase = 3'd2; idle1(); ticks(20);
        phase = 3'd1; idle1(); ticks(36);
        chk(!safety_expired, "R9 phase change restarts", safety_expired, 0);
        ticks(1); chk(safety_expired, "R3 trickle limit", safety_expired, 1);
        rearm();
        // R9 chg_en low clears count
        ticks(20); chg_en = 1'b0; idle1(); chg_en = 1'b1; idle1(); ticks(36);
        chk(!safety_expired, "R9 disable restarts", safety_expired, 0);
        ticks(1); chk(safety_expired, "R9 expiry after restart", safety_expired, 1);
        rearm();
        // R5 half rate
        in_reg_act = 1'b1; ticks(73);
        chk(!safety_expired, "R5 input reg half rate early", safety_expired, 0);
        ticks(1); chk(safety_expired, "R5 input reg half rate", safety_expired, 1);
        rearm();
        in_reg_act = 1'b0; therm_reg_act = 1'b1; ticks(73);
        chk(!safety_expired, "R5 thermal half rate early", safety_expired, 0);
        ticks(1); chk(safety_expired, "R5 thermal half rate", safety_expired, 1);
        rearm();
        wr_cfg(6'h18); ticks(36);
        chk(!safety_expired, "R5 no slowdown early", safety_expired, 0);
        ticks(1); chk(safety_expired, "R5 no slowdown", safety_expired, 1);
        rearm(); therm_reg_act = 1'b0;
        // R4 fast limits
        wr_cfg(6'h30); phase = 3'd3; idle1(); ticks(869);
        chk(!safety_expired, "R4 fast std early", safety_expired, 0);
        ticks(1); chk(safety_expired, "R4 fast std", safety_expired, 1);
        rearm();
        wr_cfg(6'h34); ticks(1679);
        chk(!safety_expired, "R4 fast long early", safety_expired, 0);
        ticks(1); chk(safety_expired, "R4 fast long", safety_expired, 1);
        rearm();
        // R6 disabled
        wr_cfg(6'h28); phase = 3'd2; idle1(); ticks(200);
        chk(!safety_expired, "R6 disabled timer", safety_expired, 0);
        // R10 top-off
        phase = 3'd4; wr_cfg(6'h31); ticks(16);
        chk(!topoff_done, "R10 code1 early", topoff_done, 0);
        ticks(1); chk(topoff_done, "R10 code1", topoff_done, 1);
        ticks(5); chk(topoff_done, "R10 holds", topoff_done, 1);
        phase = 3'd0; idle1(); chk(!topoff_done, "R10 leave clears", topoff_done, 0);
        wr_cfg(6'h32); phase = 3'd4; idle1(); in_reg_act = 1'b1; ticks(34);
        chk(!topoff_done, "R10 code2 early", topoff_done, 0);
        ticks(1); chk(topoff_done, "R10 code2 unslowed", topoff_done, 1);
        in_reg_act = 1'b0; phase = 3'd0; idle1();
        wr_cfg(6'h23); phase = 3'd4; idle1(); ticks(51);
        chk(!topoff_done, "R10 code3 early", topoff_done, 0);
        ticks(1); chk(topoff_done, "R10 code3", topoff_done, 1);
        phase = 3'd0; idle1();
        wr_cfg(6'h30); phase = 3'd4; idle1(); ticks(100);
        chk(!topoff_done, "R10 code0 never", topoff_done, 0);
        phase = 3'd0; idle1();
        // R11 register reset
        wr_cfg(6'h38); phase = 3'd2; idle1(); ticks(30);
        reg_reset = 1'b1; idle1(); reg_reset = 1'b0;
        chk(cfg_rdata == 6'h30, "R11 cfg restored", cfg_rdata, 6'h30);
        ticks(149); chk(!safety_expired, "R11 timer restarted", safety_expired, 0);
        ticks(1); chk(safety_expired, "R11 default limit", safety_expired, 1);
        reg_reset = 1'b1; idle1(); reg_reset = 1'b0;
        chk(!safety_expired, "R11 clears expiry", safety_expired, 0);
        // Random phase against model
        wr_cfg(6'h38);
        for (int i = 0; i < 4000; i++) begin
            tick          = ($urandom % 4) != 0;
            in_reg_act    = ($urandom % 4) == 0;
            therm_reg_act = ($urandom % 8) == 0;
            if (($urandom % 100) == 0) phase = 3'($urandom % 5);
            chg_en        = ($urandom % 300) != 0;
            cfg_wr        = ($urandom % 200) == 0;
            cfg_wdata     = 6'($urandom) | 6'h08;
            reg_reset     = ($urandom % 1000) == 0;
            @(negedge clk);
        end
        cfg_wr = 1'b0; reg_reset = 1'b0; tick = 1'b0;
        idle1();
        finish_run();
    end
endmodule